// File: doc/BRIEF.md
# Result Output Serializer With Status Word

This block sits between a lookup engine and a narrow synchronous output bus. Each result from the engine is 80 bits wide and arrives with a 26-bit address index and six status flags. The block packs the index and flags into one 32-bit status word. It then sends the whole result out over a bus that is `PORT_W` bits wide (32 or 16), one word at a time. The data words go out least significant word first and are right-aligned. The status word goes out either ahead of the data or after it, as configuration selects.

The receiver paces the transfer. It pulls an active-low advance input low to step the bus to the next word. An active-low strobe marks the start of each new result for exactly one clock cycle. The strobe can fall in the same cycle as the first word, or one cycle earlier. A separate active-low output enable decides whether the bus is driven or left quiet. A one-entry holding register takes the next result while the current one is still being unloaded. While that register is full, the engine is stalled.

The control is a three-state machine:
- `ST_IDLE` waits for a pending result.
- `ST_LEAD` is the early-strobe cycle.
- `ST_SHOW` presents one word and waits for an advance.

The transitions are:
- IDLE→LEAD: a result is pending and the early strobe is configured.
- IDLE→SHOW: a result is pending and the same-cycle strobe is configured.
- LEAD→SHOW: always, after one cycle.
- SHOW→SHOW: an advance on a word that is not the last steps to the next word; with no advance, the same word is held.
- SHOW→IDLE: an advance on the last word.

Top module: `result_serializer`

## Requirements
- R1: After reset, `dout` is all zero, `dout_valid_n` is 1, `in_ready` is 1, and the block is idle.
- R2: Data words are sent least significant word first. Word k carries result bits [k*PORT_W +: PORT_W], and bits above bit 79 are zero. This gives 3 data words at PORT_W=32, with bits 79..64 in the low half of the third word, and 5 data words at PORT_W=16.
- R3: The status word has this layout: bits 25..0 hold the index, bit 26 the sync-side write exception, bit 27 the processor-side write exception, bit 28 the learned-queue flag, bit 29 the aged-queue flag, bit 30 match and bit 31 full.
- R4: With `cfg_stat_first`=1 the status word is sent before the data words; with 0 it is sent after them. At PORT_W=16 the status word goes out as two words, bits 15..0 first. Both configuration inputs are captured when a result is loaded.
- R5: `dout_valid_n` is low for exactly one cycle per result. With `cfg_early_strobe`=0 that cycle is the one in which the first word appears. With `cfg_early_strobe`=1 it is the cycle before, and in that cycle `dout` is zero.
- R6: While a word is shown, `adv_n`=0 at a rising edge moves to the next word, and `adv_n`=1 holds the current word. `adv_n` is ignored when no word is being shown.
- R7: An advance on the last word returns the block to idle, where `dout` is zero. It then waits for the next result.
- R8: `in_ready` is 1 exactly when the holding register is empty. A result offered while it is full is not taken. A held result is loaded at the first rising edge at which the block is idle, and the first strobe or word follows in the next cycle.
- R9: With `oe_n`=1, `dout` is all zero and `dout_en` is 0. Sequencing and advancing go on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_stat_first | input | 1 | 1: status word before data; 0: after |
| cfg_early_strobe | input | 1 | 1: strobe one cycle ahead of the first word |
| in_valid | input | 1 | Engine offers a result |
| in_ready | output | 1 | Holding register empty |
| in_result | input | DATA_W | Result payload |
| in_index | input | 26 | Address index |
| in_swex | input | 1 | Sync-side write exception flag |
| in_pwex | input | 1 | Processor-side write exception flag |
| in_learned | input | 1 | Learned-queue flag |
| in_aged | input | 1 | Aged-queue flag |
| in_match | input | 1 | Match flag |
| in_full | input | 1 | Full flag |
| adv_n | input | 1 | Active-low advance to next word |
| oe_n | input | 1 | Active-low output drive enable |
| dout | output | PORT_W | Output word |
| dout_en | output | 1 | Bus driven |
| dout_valid_n | output | 1 | Active-low new-result strobe |

## Verification
The assertions watch several rules on every cycle:
- the strobe is never low for two cycles in a row, and the lead cycle always leads into the first word;
- a held word stays put without an advance, and an advance on the last word always ends in idle;
- the holding register keeps its contents until it is loaded, and the captured word order stays fixed during a frame.

Only the bench's scenarios can show the actual word values and their order. These cover both status placements and both port widths, the 0x56ABCDEF status pattern, and the zero padding of the top data word. They also cover the one-cycle offset of the early strobe, the back-pressure when a second result arrives during a transfer, and output-enable gating while advancing.

// File: rtl/rsz_pkg.sv
package rsz_pkg;

    localparam int STAT_W = 32;
    localparam int IDX_W  = 26;

    // Bit order is fixed by the downstream decoder: index at bottom, full at top.
    typedef struct packed {
        logic             full;
        logic             match;
        logic             aged_q;
        logic             learned_q;
        logic             proc_wex;
        logic             sync_wex;
        logic [IDX_W-1:0] index;
    } status_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_SHOW = 2'd2
    } rsz_state_e;

endpackage

// File: rtl/rsz_hold.sv
module rsz_hold
    import rsz_pkg::*;
#(
    parameter int DATA_W = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  status_t           in_stat,
    input  logic              load,
    output logic              in_ready,
    output logic              pend,
    output logic [DATA_W-1:0] q_data,
    output status_t           q_stat
);

    logic full_q;
    logic accept;

    assign accept   = in_valid && !full_q;
    assign in_ready = !full_q;
    assign pend     = full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            q_data <= '0;
            q_stat <= '0;
        end else if (accept) begin
            full_q <= 1'b1;
            q_data <= in_data;
            q_stat <= in_stat;
        end else if (load) begin
            full_q <= 1'b0;
        end
    end

    // R8: taking a result closes the door for the next cycle
    assert_take_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R8: a waiting result is neither lost nor overwritten
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !load) |=> (pend && $stable(q_data) && $stable(q_stat)));

    // R8: the sequencer only loads when something is waiting
    assert_load_needs_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> pend);

endmodule

// File: rtl/rsz_fsm.sv
module rsz_fsm
    import rsz_pkg::*;
#(
    parameter int  SLOTS = 4,
    localparam int IW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pend,
    input  logic          cfg_early,
    input  logic          adv_n,
    output logic          load,
    output logic [IW-1:0] pos,
    output logic          show,
    output logic          valid_n
);

    localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

    rsz_state_e    state_q, state_d;
    logic [IW-1:0] pos_q, pos_d;
    logic          first_q, first_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            first_q <= first_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        first_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pend) begin
                    pos_d = '0;
                    if (cfg_early) begin
                        state_d = ST_LEAD;
                    end else begin
                        state_d = ST_SHOW;
                        first_d = 1'b1;
                    end
                end
            end
            ST_LEAD: begin
                state_d = ST_SHOW;
                pos_d   = '0;
            end
            ST_SHOW: begin
                if (!adv_n) begin
                    if (pos_q == LAST) begin
                        state_d = ST_IDLE;
                        pos_d   = '0;
                    end else begin
                        pos_d = pos_q + IW'(1);
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                pos_d   = '0;
            end
        endcase
    end

    always_comb begin
        load    = (state_q == ST_IDLE) && pend;
        show    = (state_q == ST_SHOW);
        valid_n = !((state_q == ST_LEAD) || ((state_q == ST_SHOW) && first_q));
        pos     = pos_q;
    end

    // R5: the strobe never stays low past one cycle
    assert_one_low_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_n |=> valid_n);

    // R5: an early strobe is followed by the first word
    assert_lead_then_show_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD) |=> ((state_q == ST_SHOW) && (pos_q == '0)));

    // R6: without an advance the shown word stays put
    assert_hold_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SHOW) && adv_n) |=> ((state_q == ST_SHOW) && $stable(pos_q)));

    // R7: advancing past the last word ends the frame
    assert_end_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SHOW) && (pos_q == LAST) && !adv_n) |=> (state_q == ST_IDLE));

    // R2: the word pointer never leaves the frame
    assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST);

endmodule

// File: rtl/rsz_words.sv
module rsz_words
    import rsz_pkg::*;
#(
    parameter int  DATA_W = 80,
    parameter int  PORT_W = 32,
    localparam int N_DW   = (DATA_W + PORT_W - 1) / PORT_W,
    localparam int N_SW   = STAT_W / PORT_W,
    localparam int SLOTS  = N_DW + N_SW,
    localparam int IW     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int PAD_W  = N_DW * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              cfg_stat_first,
    input  logic [DATA_W-1:0] in_data,
    input  status_t           in_stat,
    input  logic [IW-1:0]     pos,
    output logic [PORT_W-1:0] word
);

    logic [DATA_W-1:0] act_data_q;
    logic [STAT_W-1:0] act_stat_q;
    logic              sf_q;
    logic [PAD_W-1:0]  pad;

    logic [PORT_W-1:0] dw      [N_DW];
    logic [PORT_W-1:0] sw      [N_SW];
    logic [PORT_W-1:0] slot_sf [SLOTS];
    logic [PORT_W-1:0] slot_df [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_data_q <= '0;
            act_stat_q <= '0;
            sf_q       <= 1'b0;
        end else if (load) begin
            act_data_q <= in_data;
            act_stat_q <= in_stat;
            sf_q       <= cfg_stat_first;
        end
    end

    generate
        if (PAD_W > DATA_W) begin : g_pad
            assign pad = {{(PAD_W - DATA_W){1'b0}}, act_data_q};
        end else begin : g_nopad
            assign pad = act_data_q;
        end

        for (genvar d = 0; d < N_DW; d++) begin : g_dw
            assign dw[d] = pad[d*PORT_W +: PORT_W];
        end

        for (genvar s = 0; s < N_SW; s++) begin : g_sw
            assign sw[s] = act_stat_q[s*PORT_W +: PORT_W];
        end

        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            if (g < N_SW) begin : g_sf_stat
                assign slot_sf[g] = sw[g];
            end else begin : g_sf_data
                assign slot_sf[g] = dw[g - N_SW];
            end
            if (g < N_DW) begin : g_df_data
                assign slot_df[g] = dw[g];
            end else begin : g_df_stat
                assign slot_df[g] = sw[g - N_DW];
            end
        end
    endgenerate

    assign word = sf_q ? slot_sf[pos] : slot_df[pos];

    // R4: word order is frozen for the life of a frame
    assert_order_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(sf_q) && $stable(act_data_q) && $stable(act_stat_q)));

endmodule

// File: rtl/result_serializer.sv
module result_serializer
    import rsz_pkg::*;
#(
    parameter int DATA_W = 80,
    parameter int PORT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_stat_first,
    input  logic              cfg_early_strobe,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_result,
    input  logic [IDX_W-1:0]  in_index,
    input  logic              in_swex,
    input  logic              in_pwex,
    input  logic              in_learned,
    input  logic              in_aged,
    input  logic              in_match,
    input  logic              in_full,
    input  logic              adv_n,
    input  logic              oe_n,
    output logic [PORT_W-1:0] dout,
    output logic              dout_en,
    output logic              dout_valid_n
);

    localparam int N_DW  = (DATA_W + PORT_W - 1) / PORT_W;
    localparam int N_SW  = STAT_W / PORT_W;
    localparam int SLOTS = N_DW + N_SW;
    localparam int IW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    status_t           in_stat;
    status_t           q_stat;
    logic [DATA_W-1:0] q_data;
    logic              pend;
    logic              load;
    logic              show;
    logic [IW-1:0]     pos;
    logic [PORT_W-1:0] word;

    always_comb begin
        in_stat.full      = in_full;
        in_stat.match     = in_match;
        in_stat.aged_q    = in_aged;
        in_stat.learned_q = in_learned;
        in_stat.proc_wex  = in_pwex;
        in_stat.sync_wex  = in_swex;
        in_stat.index     = in_index;
    end

    rsz_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_result),
        .in_stat  (in_stat),
        .load     (load),
        .in_ready (in_ready),
        .pend     (pend),
        .q_data   (q_data),
        .q_stat   (q_stat)
    );

    rsz_fsm #(.SLOTS(SLOTS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .cfg_early (cfg_early_strobe),
        .adv_n     (adv_n),
        .load      (load),
        .pos       (pos),
        .show      (show),
        .valid_n   (dout_valid_n)
    );

    rsz_words #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u_words (
        .clk            (clk),
        .rst_n          (rst_n),
        .load           (load),
        .cfg_stat_first (cfg_stat_first),
        .in_data        (q_data),
        .in_stat        (q_stat),
        .pos            (pos),
        .word           (word)
    );

    assign dout    = (show && !oe_n) ? word : '0;
    assign dout_en = !oe_n;

endmodule

// File: tb/sim_result_serializer.sv
package sim_rsz_pkg;
    function automatic logic [31:0] exp_word(int pw, logic [79:0] d, logic [31:0] s,
                                            bit sfirst, int k);
        int          nd;
        int          ns;
        logic [95:0] pad;
        logic [31:0] mask;
        nd   = (80 + pw - 1) / pw;
        ns   = 32 / pw;
        pad  = {16'h0, d};
        mask = (pw == 32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        if (sfirst) begin
            if (k < ns) return (s >> (k * pw)) & mask;
            return 32'(pad >> ((k - ns) * pw)) & mask;
        end
        if (k < nd) return 32'(pad >> (k * pw)) & mask;
        return (s >> ((k - nd) * pw)) & mask;
    endfunction
endpackage

module sim_ref #(parameter int PW = 32) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [79:0] data,
    input  logic [31:0] stat,
    input  logic        cfg_first,
    input  logic        cfg_early,
    input  logic        adv_n,
    input  logic        oe_n,
    output logic [31:0] exp_dout,
    output logic        exp_valid_n,
    output logic        exp_ready
);
    import sim_rsz_pkg::*;
    localparam int TOTAL = (80 + PW - 1) / PW + 32 / PW;
    bit          pend, lead, showing, first_show, asf;
    logic [79:0] pd, ad;
    logic [31:0] ps, as_;
    int          ptr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend = 0; lead = 0; showing = 0; first_show = 0; asf = 0;
            pd = '0; ad = '0; ps = '0; as_ = '0; ptr = 0;
        end else begin
            bit pp;
            pp = pend;
            if (lead) begin
                lead = 0; showing = 1; first_show = 0;
            end else if (showing) begin
                first_show = 0;
                if (!adv_n) begin
                    ptr++;
                    if (ptr == TOTAL) begin showing = 0; ptr = 0; end
                end
            end else if (pp) begin
                ad = pd; as_ = ps; asf = cfg_first; ptr = 0; pend = 0;
                if (cfg_early) begin lead = 1; first_show = 0; end
                else begin showing = 1; first_show = 1; end
            end
            if (in_valid && !pp) begin pend = 1; pd = data; ps = stat; end
        end
    end

    always_comb begin
        exp_valid_n = !(lead || (showing && first_show));
        exp_ready   = !pend;
        exp_dout    = (showing && !oe_n) ? exp_word(PW, ad, as_, asf, ptr) : 32'h0;
    end
endmodule

module sim_result_serializer;
    import sim_rsz_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_stat_first = 0, cfg_early_strobe = 0;
    logic        in_valid = 0;
    logic [79:0] in_result = '0;
    logic [25:0] in_index = '0;
    logic [5:0]  flags = '0;
    logic        adv_n = 1, oe_n = 0;
    logic [31:0] stat;
    logic        rdy0, rdy1, en0, en1, vn0, vn1;
    logic [31:0] d0;
    logic [15:0] d1;
    logic [31:0] e0, e1;
    logic        ev0, ev1, er0, er1;
    int          checks = 0, fails = 0;
    bit          done = 0, run_cmp = 0;

    assign stat = {flags, in_index};
    always #(CLK_PERIOD/2) clk = ~clk;

    result_serializer #(.DATA_W(80), .PORT_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_stat_first(cfg_stat_first),
        .cfg_early_strobe(cfg_early_strobe), .in_valid(in_valid), .in_ready(rdy0),
        .in_result(in_result), .in_index(in_index), .in_swex(flags[0]),
        .in_pwex(flags[1]), .in_learned(flags[2]), .in_aged(flags[3]),
        .in_match(flags[4]), .in_full(flags[5]), .adv_n(adv_n), .oe_n(oe_n),
        .dout(d0), .dout_en(en0), .dout_valid_n(vn0));

    result_serializer #(.DATA_W(80), .PORT_W(16)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_stat_first(cfg_stat_first),
        .cfg_early_strobe(cfg_early_strobe), .in_valid(in_valid), .in_ready(rdy1),
        .in_result(in_result), .in_index(in_index), .in_swex(flags[0]),
        .in_pwex(flags[1]), .in_learned(flags[2]), .in_aged(flags[3]),
        .in_match(flags[4]), .in_full(flags[5]), .adv_n(adv_n), .oe_n(oe_n),
        .dout(d1), .dout_en(en1), .dout_valid_n(vn1));

    sim_ref #(.PW(32)) m0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data(in_result),
        .stat(stat), .cfg_first(cfg_stat_first), .cfg_early(cfg_early_strobe),
        .adv_n(adv_n), .oe_n(oe_n), .exp_dout(e0), .exp_valid_n(ev0), .exp_ready(er0));
    sim_ref #(.PW(16)) m1 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data(in_result),
        .stat(stat), .cfg_first(cfg_stat_first), .cfg_early(cfg_early_strobe),
        .adv_n(adv_n), .oe_n(oe_n), .exp_dout(e1), .exp_valid_n(ev1), .exp_ready(er1));

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the behavioural model, both port widths
    always @(negedge clk) begin
        if (run_cmp) begin
            check(d0 == e0, "R2 dout w32", d0, e0);
            check(vn0 == ev0, "R5 strobe w32", 32'(vn0), 32'(ev0));
            check(rdy0 == er0, "R8 ready w32", 32'(rdy0), 32'(er0));
            check(en0 == !oe_n, "R9 enable w32", 32'(en0), 32'(!oe_n));
            check({16'h0, d1} == e1, "R4 dout w16", {16'h0, d1}, e1);
            check(vn1 == ev1, "R5 strobe w16", 32'(vn1), 32'(ev1));
            check(rdy1 == er1, "R8 ready w16", 32'(rdy1), 32'(er1));
        end
    end

    task automatic offer(logic [79:0] d, logic [25:0] ix, logic [5:0] f, bit sf, bit er);
        @(posedge clk); #2;
        in_valid = 1; in_result = d; in_index = ix; flags = f;
        cfg_stat_first = sf; cfg_early_strobe = er;
        @(posedge clk); #2;
        in_valid = 0;
    endtask

    task automatic flush();
        adv_n = 0;
        repeat (12) @(negedge clk);
        check(vn0 == 1 && d0 == 0, "R6 advance ignored when idle", d0, 32'h0);
        adv_n = 1;
    endtask

    task automatic run_frame(logic [79:0] d, logic [25:0] ix, logic [5:0] f, bit sf, bit er,
                             output logic [31:0] stat_seen);
        logic [31:0] s;
        string       tag;
        s   = {f, ix};
        tag = sf ? "R4 order" : "R2 data order";
        offer(d, ix, f, sf, er);
        @(negedge clk);
        check(rdy0 == 0, "R8 ready low while held", 32'(rdy0), 32'h0);
        @(negedge clk);
        if (er) begin
            check(vn0 == 0, "R5 early strobe", 32'(vn0), 32'h0);
            check(d0 == 0, "R5 no data in lead cycle", d0, 32'h0);
            @(negedge clk);
            check(vn0 == 1, "R5 strobe gone with first word", 32'(vn0), 32'h1);
        end else begin
            check(vn0 == 0, "R5 strobe with first word", 32'(vn0), 32'h0);
        end
        check(d0 == exp_word(32, d, s, sf, 0), tag, d0, exp_word(32, d, s, sf, 0));
        stat_seen = sf ? d0 : 32'h0;
        @(negedge clk);
        check(d0 == exp_word(32, d, s, sf, 0) && vn0 == 1, "R6 word held", d0,
              exp_word(32, d, s, sf, 0));
        adv_n = 0;
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            check(d0 == exp_word(32, d, s, sf, k), tag, d0, exp_word(32, d, s, sf, k));
            if (!sf && k == 3) stat_seen = d0;
        end
        @(negedge clk);
        check(d0 == 0 && vn0 == 1, "R7 idle after last word", d0, 32'h0);
        flush();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] sseen;
        repeat (3) @(negedge clk);
        check(d0 == 0, "R1 reset dout", d0, 32'h0);
        check(vn0 == 1, "R1 reset strobe", 32'(vn0), 32'h1);
        check(rdy0 == 1 && rdy1 == 1, "R1 reset ready", 32'(rdy0), 32'h1);
        @(posedge clk); #2; rst_n = 1;
        run_cmp = 1;

        // Status after data, same-cycle strobe
        run_frame(80'hABCD_0123_4567_89AB_CDEF, 26'h2ABCDEF, 6'b010101, 0, 0, sseen);
        check(sseen == 32'h56AB_CDEF, "R3 status layout", sseen, 32'h56AB_CDEF);
        check(exp_word(32, 80'hABCD_0123_4567_89AB_CDEF, 0, 0, 2) == 32'h0000_ABCD,
              "R2 top word zero padded", 32'h0, 32'h0);

        // Status before data, early strobe
        run_frame(80'h1357_2468_ACE0_BDF1_9753, 26'h0000155, 6'b101010, 1, 1, sseen);
        check(sseen == 32'hA800_0155, "R3 R4 status first", sseen, 32'hA800_0155);

        // Back-pressure: second result waits, third refused
        offer(80'h1111_2222_3333_4444_5555, 26'h1, 6'h0, 0, 0);
        offer(80'h6666_7777_8888_9999_AAAA, 26'h2, 6'h3F, 1, 0);
        @(negedge clk);
        check(rdy0 == 0, "R8 second held during transfer", 32'(rdy0), 32'h0);
        offer(80'hBBBB_CCCC_DDDD_EEEE_FFFF, 26'h3, 6'h0, 0, 1);
        @(negedge clk);
        check(rdy0 == 0, "R8 third refused", 32'(rdy0), 32'h0);

        // Output enable gating while advancing
        @(posedge clk); #2; oe_n = 1; adv_n = 0;
        @(negedge clk);
        check(d0 == 0 && en0 == 0, "R9 quiet bus", d0, 32'h0);
        @(posedge clk); #2; oe_n = 0;
        repeat (30) @(negedge clk);
        adv_n = 1;

        // Randomised traffic
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #2;
            in_valid         = ($urandom % 4) == 0;
            in_result        = {16'($urandom), $urandom, $urandom};
            in_index         = 26'($urandom);
            flags            = 6'($urandom);
            cfg_stat_first   = 1'($urandom);
            cfg_early_strobe = 1'($urandom);
            adv_n            = ($urandom % 3) == 0;
            oe_n             = ($urandom % 8) == 0;
        end
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule